// File: doc/BRIEF.md
# Pipelined ADC Digital Error Correction

This block turns the per-stage comparator decisions of a nine-stage pipelined converter into one corrected 10-bit offset-binary sample per clock. The first eight stages each report a redundant three-level decision. The ninth stage reports a 2-bit flash code. A sample moves one stage further every half clock, so each stage reports its decision for a given sample in a later cycle than the stage before it. The block delays each stage's decision by a different amount, so that all nine decisions of one sample meet in the same cycle. It then adds the overlapping weights and registers the word.

Neighbouring stage weights overlap by one bit. A comparator that trips early or late is therefore absorbed by the stages downstream, and no output code goes missing. Two identical channels share one clock and one reset. Each channel also carries a flag that marks a sample in which a three-level stage reported the illegal value 3.

Top module: `pdc_top`

## Requirements
- R1: Stage k (k = 1..8) reports on bits [2k-1:2k-2] of its channel's stage bus, with 0, 1 and 2 legal. The flash code is a 2-bit unsigned value. The output word equals the sum over k of code_k·2^(9-k), plus the flash code.
- R2: If a sample is taken at clock edge S, stage k's code is held on its bus during the cycle that ends at edge S+1+floor((k-1)/2). The flash code is held during the cycle that ends at edge S+5. The corrected word and its flag update at edge S+5.
- R3: Each stage's two comparator thresholds, nominally at ±1/4 of full scale, may each be displaced by up to 1/8 of full scale. With such displacements the output still equals the ideal 10-bit quantization floor((v+1)·512) of the input v in [-1, 1), and all 1024 codes are reachable.
- R4: The error flag is high with the word of a sample exactly when at least one of that sample's eight three-level codes equals 3. It is low otherwise.
- R5: If the weighted sum exceeds 1023, the word is 1023.
- R6: Reset is asynchronous and active low. While reset is asserted, and after the first four clock edges that follow its release, both words read 512 and both flags read 0. The fifth edge after release delivers the first sample.
- R7: The two channels are independent. Each channel's word and flag depend only on its own stage and flash inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_stg_i | input | 16 | Channel A three-level stage codes, stage k at bits [2k-1:2k-2] |
| a_fin_i | input | 2 | Channel A final 2-bit flash code |
| b_stg_i | input | 16 | Channel B three-level stage codes, same layout |
| b_fin_i | input | 2 | Channel B final 2-bit flash code |
| a_dat_o | output | 10 | Channel A corrected word, offset binary |
| a_err_o | output | 1 | Channel A illegal-code flag for the sample in a_dat_o |
| b_dat_o | output | 10 | Channel B corrected word, offset binary |
| b_err_o | output | 1 | Channel B illegal-code flag for the sample in b_dat_o |

## Verification
The bench assigns every sample a launch edge S. It presents stage k's code in the cycle that ends at edge S+1+floor((k-1)/2) and the flash code in the cycle that ends at S+5. It then reads the word and the flag on the falling edge after edge S+5, so each check lands exactly five edges after the sample's launch. During the four edges of the warm-up window, the bench drives codes that would produce a value other than mid-scale, and it expects 512 on those falling edges.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef logic [1:0] code_t;
  localparam code_t CODE_BAD = 2'd3;
endpackage

// File: rtl/pdc_align.sv
module pdc_align
  import pdc_pkg::*;
#(
  parameter int N_RED = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2*N_RED-1:0] stg_i,
  output logic [2*N_RED-1:0] al_o
);
  // stage k is late by k/2 cycles; pad so all stages meet the flash code
  for (genvar k = 0; k < N_RED; k++) begin : g_stg
    localparam int DEP = N_RED/2 - k/2;
    if (DEP == 0) begin : g_thru
      assign al_o[2*k +: 2] = stg_i[2*k +: 2];
    end else begin : g_dly
      code_t sh_q [DEP];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int j = 0; j < DEP; j++) sh_q[j] <= '0;
        end else begin
          sh_q[0] <= stg_i[2*k +: 2];
          for (int j = 1; j < DEP; j++) sh_q[j] <= sh_q[j-1];
        end
      end
      assign al_o[2*k +: 2] = sh_q[DEP-1];
    end
  end
endmodule

// File: rtl/pdc_combine.sv
module pdc_combine
  import pdc_pkg::*;
#(
  parameter int N_RED = 8
) (
  input  logic [2*N_RED-1:0] al_i,
  input  logic [1:0]         fin_i,
  output logic [N_RED+1:0]   sum_o,
  output logic               bad_o
);
  localparam int W  = N_RED + 2;
  localparam int AW = W + 2;
  localparam logic [AW-1:0] TOP = AW'((1 << W) - 1);

  logic [AW-1:0] acc;

  always_comb begin
    acc   = AW'(fin_i);
    bad_o = 1'b0;
    for (int k = 0; k < N_RED; k++) begin
      acc   = acc + (AW'(al_i[2*k +: 2]) << (N_RED - k));
      bad_o = bad_o | (al_i[2*k +: 2] == CODE_BAD);
    end
    sum_o = (acc > TOP) ? '1 : acc[W-1:0];
  end
endmodule

// File: rtl/pdc_channel.sv
module pdc_channel #(
  parameter int N_RED = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               live_i,
  input  logic [2*N_RED-1:0] stg_i,
  input  logic [1:0]         fin_i,
  output logic [N_RED+1:0]   dat_o,
  output logic               err_o
);
  localparam int W = N_RED + 2;
  localparam logic [W-1:0] MID = W'(1 << (W - 1));

  logic [2*N_RED-1:0] al;
  logic [W-1:0]       sum;
  logic               bad;

  pdc_align #(.N_RED(N_RED)) u_align (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stg_i (stg_i),
    .al_o  (al)
  );

  pdc_combine #(.N_RED(N_RED)) u_comb (
    .al_i (al),
    .fin_i(fin_i),
    .sum_o(sum),
    .bad_o(bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_o <= MID;
      err_o <= 1'b0;
    end else if (live_i) begin
      dat_o <= sum;
      err_o <= bad;
    end
  end
endmodule

// File: rtl/pdc_top.sv
module pdc_top #(
  parameter int N_RED = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2*N_RED-1:0] a_stg_i,
  input  logic [1:0]         a_fin_i,
  input  logic [2*N_RED-1:0] b_stg_i,
  input  logic [1:0]         b_fin_i,
  output logic [N_RED+1:0]   a_dat_o,
  output logic               a_err_o,
  output logic [N_RED+1:0]   b_dat_o,
  output logic               b_err_o
);
  localparam int LAT = N_RED/2 + 1;
  localparam int CW  = $clog2(LAT + 1);

  // warm-up: hold mid-scale until the first fully aligned sample
  logic [CW-1:0] fill_q;
  logic          live;

  assign live = (fill_q == CW'(LAT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fill_q <= '0;
    else if (!live) fill_q <= fill_q + 1'b1;
  end

  pdc_channel #(.N_RED(N_RED)) u_ch_a (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .live_i(live),
    .stg_i (a_stg_i),
    .fin_i (a_fin_i),
    .dat_o (a_dat_o),
    .err_o (a_err_o)
  );

  pdc_channel #(.N_RED(N_RED)) u_ch_b (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .live_i(live),
    .stg_i (b_stg_i),
    .fin_i (b_fin_i),
    .dat_o (b_dat_o),
    .err_o (b_err_o)
  );
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk #(
  parameter int N_RED = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2*N_RED-1:0] a_stg_i,
  input logic [1:0]         a_fin_i,
  input logic [1:0]         b_fin_i,
  input logic [N_RED+1:0]   a_dat_o,
  input logic               a_err_o,
  input logic [N_RED+1:0]   b_dat_o,
  input logic               b_err_o
);
  localparam int W   = N_RED + 2;
  localparam int LAT = N_RED/2 + 1;
  localparam int CW  = $clog2(LAT + 1);
  localparam logic [W-1:0] MID = W'(1 << (W - 1));

  logic [CW-1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 seen_q <= '0;
    else if (seen_q != CW'(LAT)) seen_q <= seen_q + 1'b1;
  end

  a_r6_warm_mid_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q < CW'(LAT)) |-> (a_dat_o == MID && !a_err_o));

  a_r6_warm_mid_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q < CW'(LAT)) |-> (b_dat_o == MID && !b_err_o));

  // legal sum never saturates; only the flash code has unit weight
  a_r1_lsb_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == CW'(LAT) && !a_err_o) |-> (a_dat_o[0] == $past(a_fin_i[0])));

  a_r7_lsb_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == CW'(LAT) && !b_err_o) |-> (b_dat_o[0] == $past(b_fin_i[0])));

  // last three-level stage: one alignment register plus the output register
  a_r4_bad_last_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == CW'(LAT) && $past(a_stg_i[2*N_RED-1 -: 2], 2) == 2'd3) |-> a_err_o);
endmodule

bind pdc_top pdc_chk #(.N_RED(N_RED)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .a_stg_i(a_stg_i),
  .a_fin_i(a_fin_i),
  .b_fin_i(b_fin_i),
  .a_dat_o(a_dat_o),
  .a_err_o(a_err_o),
  .b_dat_o(b_dat_o),
  .b_err_o(b_err_o)
);

// File: tb/tb_pdc_top.sv
`timescale 1ns/1ps
module tb_pdc_top;
  localparam int NR  = 8;
  localparam int W   = NR + 2;
  localparam int LAT = NR/2 + 1;
  localparam int NS  = 1100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [2*NR-1:0] a_stg_i = '0, b_stg_i = '0;
  logic [1:0] a_fin_i = '0, b_fin_i = '0;
  logic [W-1:0] a_dat_o, b_dat_o;
  logic a_err_o, b_err_o;

  int n_chk = 0, n_bad = 0;
  logic [1023:0] hit;

  always #4 clk_i = ~clk_i;

  pdc_top #(.N_RED(NR)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_stg_i(a_stg_i), .a_fin_i(a_fin_i),
    .b_stg_i(b_stg_i), .b_fin_i(b_fin_i),
    .a_dat_o(a_dat_o), .a_err_o(a_err_o),
    .b_dat_o(b_dat_o), .b_err_o(b_err_o)
  );

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int seed_of(int ph, int ch);
    return (ph == 0 || ph == 3) ? 0 : ph*2 + ch;
  endfunction

  // threshold displacement in units of 2^-15 full scale, |d| < 1/8
  function automatic int off_hi(int sd, int k);
    return (sd == 0) ? 0 : ((k*2741 + sd*1319) % 7601) - 3800;
  endfunction
  function automatic int off_lo(int sd, int k);
    return (sd == 0) ? 0 : ((k*1913 + sd*2203) % 7601) - 3800;
  endfunction

  function automatic int smp_x(int ph, int ch, int s);
    int c = s % 1024;
    if (ch == 1) c = 1023 - c;
    return c*64 - 32768 + ((s*37 + ph*11 + ch*5) % 64);
  endfunction

  function automatic bit crafted(int ph, int s);
    return (ph == 3) && (s >= 0) && (s < 3);
  endfunction

  // ideal 1.5-bit pipeline with displaced comparators
  function automatic int code_of(int ph, int ch, int s, int k);
    int r, d, f, sd;
    if (s < 0) return (k < NR) ? 2 : 3;
    if (crafted(ph, s)) begin
      if (s == 0) return 3;
      if (s == 1) return (k == 0) ? 3 : 0;
      return (k == NR-1) ? 3 : ((k == NR) ? 2 : 1);
    end
    sd = seed_of(ph, ch);
    r = smp_x(ph, ch, s);
    for (int j = 0; j < NR; j++) begin
      if (r > 8192 + off_hi(sd, j))       d = 2;
      else if (r < -8192 + off_lo(sd, j)) d = 0;
      else                                d = 1;
      if (j == k) return d;
      r = 2*r - (d - 1)*32768;
    end
    f = (r + 32768) >>> 14;
    if (f < 0) f = 0;
    if (f > 3) f = 3;
    return f;
  endfunction

  function automatic int exp_of(int ph, int ch, int s);
    int acc;
    if (!crafted(ph, s)) return (smp_x(ph, ch, s) + 32768) >>> 6;
    acc = code_of(ph, ch, s, NR);
    for (int k = 0; k < NR; k++) acc += code_of(ph, ch, s, k) << (NR - k);
    return (acc > 1023) ? 1023 : acc;
  endfunction

  function automatic int err_of(int ph, int ch, int s);
    for (int k = 0; k < NR; k++) if (code_of(ph, ch, s, k) == 3) return 1;
    return 0;
  endfunction

  task automatic drive(int ph, int c);
    for (int k = 0; k < NR; k++) begin
      a_stg_i[2*k +: 2] = 2'(code_of(ph, 0, c - 1 - k/2, k));
      b_stg_i[2*k +: 2] = 2'(code_of(ph, 1, c - 1 - k/2, k));
    end
    a_fin_i = 2'(code_of(ph, 0, c - 1 - NR/2, NR));
    b_fin_i = 2'(code_of(ph, 1, c - 1 - NR/2, NR));
  endtask

  task automatic run_phase(int ph, int nsamp);
    string ta, tb;
    int s;
    ta = (ph == 0) ? "R1 R2" : ((ph == 3) ? "R5" : "R3");
    tb = (ph == 3) ? "R5" : "R7 R2";
    @(negedge clk_i);
    rst_ni = 1'b0;
    drive(ph, 0);
    repeat (2) @(negedge clk_i);
    chk("R6 reset A", int'(a_dat_o), 512);
    chk("R6 reset B", int'(b_dat_o), 512);
    chk("R6 reset flag", int'(a_err_o | b_err_o), 0);
    rst_ni = 1'b1;
    for (int c = 1; c < nsamp + LAT; c++) begin
      drive(ph, c);
      @(posedge clk_i);
      @(negedge clk_i);
      if (c < LAT) begin
        chk("R6 warm A", int'(a_dat_o), 512);
        chk("R6 warm B", int'(b_dat_o), 512);
        chk("R6 warm flag", int'(a_err_o | b_err_o), 0);
      end else begin
        s = c - LAT;
        chk(ta, int'(a_dat_o), exp_of(ph, 0, s));
        chk(tb, int'(b_dat_o), exp_of(ph, 1, s));
        chk("R4 flag A", int'(a_err_o), err_of(ph, 0, s));
        chk("R4 flag B", int'(b_err_o), err_of(ph, 1, s));
        if (ph == 2) hit[a_dat_o] = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    hit = '0;
    run_phase(0, NS);
    run_phase(1, NS);
    run_phase(2, NS);
    chk("R3 all codes reached", $countones(hit), 1024);
    run_phase(3, 40);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule